// File: doc/BRIEF.md
# Ping-pong receive buffer for a USB OUT endpoint

This block stores the payload of OUT data packets for a single device endpoint. The bus side delivers bytes that have already been decoded, one per `rx_valid` strobe. `rx_eop` marks the end of the packet, and `rx_good` at that point says whether the packet checked out. When a good packet lands in a free bank, the block answers with a one-cycle ACK strobe. When no bank is free, it answers with a NAK strobe. Storage holds `NUM_BANKS` banks of `BANK_BYTES` bytes each. The bus always fills the oldest free bank, and the CPU always sees the oldest full bank.

Software works with two flags. The received flag signals that a full bank is waiting; clearing it only acknowledges the interrupt. The bank flag marks that the CPU owns the visible bank; clearing it hands the bank back and moves the view to the next bank. While it holds a bank, the CPU sizes its loop from `byte_count` and pops bytes from `rd_data` with `cpu_rd`. With two banks, the host can fill one bank while the CPU drains the other.

Top module: `usb_out_ep_buf`

## Requirements
- R1: After reset, both flags, the interrupt enable, `read_ok`, `byte_count`, `ep_irq`, `hs_ack` and `hs_nak` are all 0.
- R2: A packet ending with `rx_eop`=1 and `rx_good`=1 into a free bank drives `hs_ack` high for exactly the one cycle after the end-of-packet cycle. If that bank is next in the CPU view, both flags read 1 two cycles after the end-of-packet cycle, and `byte_count` equals the packet length.
- R3: `ep_irq` is 1 exactly when the received flag and the interrupt enable are both 1. The enable is loaded from `cpu_ie_wd` when `cpu_ie_we`=1.
- R4: A flag write (`cpu_flag_we`=1) with `cpu_flag_rxout_wd`=0 and `cpu_flag_bank_wd`=1 clears only the received flag. The bank flag, `byte_count` and `rd_data` are unchanged.
- R5: `rd_data` shows the next unread byte in arrival order. Each `cpu_rd` while `read_ok`=1 advances to the next byte and lowers `byte_count` by 1. When `byte_count` is 0, `read_ok` is 0 and a read changes nothing.
- R6: A flag write with `cpu_flag_bank_wd`=0 releases the visible bank. Both flags drop to 0 and the view moves to the next bank in ring order.
- R7: With two banks, a packet is accepted into the second bank while the CPU still holds the first. If that bank is full when the first is released, both flags are set again in the next cycle, showing the second bank's count and data. This also holds when the release falls in the same cycle as that packet's end.
- R8: A good packet that finds no free bank gets `hs_nak` in the cycle after its end. Its bytes are discarded, and the banks already held keep their data and counts.
- R9: A flag write with 1 in a flag's data bit leaves that flag unchanged.
- R10: A packet ending with `rx_good`=0 gets no handshake. The bank stays free, and the flags stay 0.
- R11: Bytes past `BANK_BYTES` in one packet are dropped, and the stored count saturates at `BANK_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | 8 | Payload byte |
| rx_eop | input | 1 | End of packet |
| rx_good | input | 1 | Packet passed checks (sampled with rx_eop) |
| hs_ack | output | 1 | ACK decision strobe |
| hs_nak | output | 1 | NAK decision strobe |
| cpu_flag_we | input | 1 | Flag write strobe |
| cpu_flag_rxout_wd | input | 1 | Received flag write data (0 clears) |
| cpu_flag_bank_wd | input | 1 | Bank flag write data (0 releases) |
| cpu_ie_we | input | 1 | Interrupt enable write strobe |
| cpu_ie_wd | input | 1 | Interrupt enable write data |
| cpu_rd | input | 1 | Pop one byte from the visible bank |
| rxout_flag | output | 1 | Received flag |
| bank_flag | output | 1 | Bank flag (CPU owns visible bank) |
| rxout_ie | output | 1 | Interrupt enable |
| read_ok | output | 1 | Unread bytes remain |
| byte_count | output | $clog2(BANK_BYTES+1) | Unread bytes in visible bank |
| rd_data | output | 8 | Next unread byte |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
The bank release by the CPU and the end of a packet into the other bank can fall in the same clock cycle. The bench provokes this by driving the release write on the same cycle as `rx_eop` of a second packet while the CPU still holds the first bank. It then expects an ACK in the next cycle and both flags back at 1 one cycle later, showing the new packet's count and first byte. A further good packet must then be ACKed into the freed bank, and one after it must get a NAK without disturbing either held bank.

// File: rtl/oep_pkg.sv
package oep_pkg;

    typedef logic [7:0] oep_byte_t;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } oep_hs_e;

endpackage

// File: rtl/oep_bank_mem.sv
module oep_bank_mem
    import oep_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
    input  logic            clk,
    input  logic            wr_en_i,
    input  logic [BW-1:0]   wr_bank_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  oep_byte_t       wr_data_i,
    input  logic [BW-1:0]   rd_bank_i,
    input  logic [AW-1:0]   rd_addr_i,
    output oep_byte_t       rd_data_o
);

    oep_byte_t bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        oep_byte_t store_q [BANK_BYTES];

        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_bank_i == BW'(b))) begin
                store_q[wr_addr_i] <= wr_data_i;
            end
        end

        assign bank_rd[b] = store_q[rd_addr_i];
    end

    always_comb begin
        rd_data_o = bank_rd[0];
        for (int b = 1; b < NUM_BANKS; b++) begin
            if (rd_bank_i == BW'(b)) begin
                rd_data_o = bank_rd[b];
            end
        end
    end

endmodule

// File: rtl/oep_rx_fill.sv
module oep_rx_fill
    import oep_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  oep_byte_t            rx_data,
    input  logic                 rx_eop,
    input  logic                 rx_good,
    input  logic [NUM_BANKS-1:0] full_i,
    output logic                 mem_we_o,
    output logic [BW-1:0]        mem_bank_o,
    output logic [AW-1:0]        mem_addr_o,
    output oep_byte_t            mem_data_o,
    output logic                 commit_o,
    output logic [BW-1:0]        commit_bank_o,
    output logic [CW-1:0]        commit_cnt_o,
    output logic                 hs_ack_o,
    output logic                 hs_nak_o
);

    localparam logic [CW-1:0] CNT_LIMIT = CW'(BANK_BYTES);
    localparam logic [BW-1:0] LAST_BANK = BW'(NUM_BANKS - 1);

    typedef struct packed {
        logic          in_pkt;
        logic          acc;
        logic [CW-1:0] wr_cnt;
        logic [BW-1:0] wr_bank;
        oep_hs_e       hs;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic     acc_now;

    always_comb begin
        st_d          = st_q;
        st_d.hs       = HS_NONE;
        mem_we_o      = 1'b0;
        commit_o      = 1'b0;
        commit_cnt_o  = st_q.wr_cnt;
        acc_now       = st_q.in_pkt ? st_q.acc : !full_i[st_q.wr_bank];

        if (rx_valid) begin
            st_d.in_pkt = 1'b1;
            st_d.acc    = acc_now;
            if (acc_now && (st_q.wr_cnt != CNT_LIMIT)) begin
                mem_we_o    = 1'b1;
                st_d.wr_cnt = st_q.wr_cnt + 1'b1;
            end
        end

        if (rx_eop) begin
            commit_cnt_o = st_d.wr_cnt;
            st_d.in_pkt  = 1'b0;
            st_d.acc     = 1'b0;
            st_d.wr_cnt  = '0;
            if (rx_good) begin
                if (acc_now) begin
                    st_d.hs  = HS_ACK;
                    commit_o = 1'b1;
                    if (NUM_BANKS > 1) begin
                        st_d.wr_bank = (st_q.wr_bank == LAST_BANK) ? '0
                                                                   : st_q.wr_bank + 1'b1;
                    end
                end else begin
                    st_d.hs = HS_NAK;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{in_pkt: 1'b0, acc: 1'b0, wr_cnt: '0, wr_bank: '0, hs: HS_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_bank_o    = st_q.wr_bank;
    assign mem_addr_o    = st_q.wr_cnt[AW-1:0];
    assign mem_data_o    = rx_data;
    assign commit_bank_o = st_q.wr_bank;
    assign hs_ack_o      = (st_q.hs == HS_ACK);
    assign hs_nak_o      = (st_q.hs == HS_NAK);

    a_r2_hs_follows_good_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ack_o || hs_nak_o) |-> $past(rx_eop && rx_good));

    a_r10_bad_packet_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eop && !rx_good) |=> (!hs_ack_o && !hs_nak_o));

    a_r11_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_cnt <= CNT_LIMIT);

    a_r8_no_write_into_full: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !full_i[mem_bank_o]);

endmodule

// File: rtl/oep_cpu_view.sv
module oep_cpu_view #(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_i,
    input  logic [BW-1:0]        commit_bank_i,
    input  logic [CW-1:0]        commit_cnt_i,
    input  logic                 flag_we_i,
    input  logic                 rxout_wd_i,
    input  logic                 bank_wd_i,
    input  logic                 ie_we_i,
    input  logic                 ie_wd_i,
    input  logic                 rd_i,
    output logic [NUM_BANKS-1:0] full_o,
    output logic [BW-1:0]        rd_bank_o,
    output logic [AW-1:0]        rd_addr_o,
    output logic                 rxout_o,
    output logic                 bankf_o,
    output logic                 ie_o,
    output logic [CW-1:0]        remain_o,
    output logic                 read_ok_o,
    output logic                 irq_o
);

    localparam logic [BW-1:0] LAST_BANK = BW'(NUM_BANKS - 1);

    typedef struct packed {
        logic [NUM_BANKS-1:0]         full;
        logic [NUM_BANKS-1:0][CW-1:0] cnt;
        logic [BW-1:0]                rd_bank;
        logic [CW-1:0]                rd_ptr;
        logic                         rxout;
        logic                         bankf;
        logic                         ie;
    } view_st_t;

    view_st_t st_d, st_q;
    logic     release_req;
    logic     pop;

    always_comb begin
        remain_o  = st_q.bankf ? (st_q.cnt[st_q.rd_bank] - st_q.rd_ptr) : '0;
        read_ok_o = (remain_o != '0);
    end

    always_comb begin
        st_d        = st_q;
        release_req = st_q.bankf && flag_we_i && !bank_wd_i;
        pop         = rd_i && read_ok_o;

        if (commit_i) begin
            st_d.full[commit_bank_i] = 1'b1;
            st_d.cnt[commit_bank_i]  = commit_cnt_i;
        end

        if (ie_we_i) begin
            st_d.ie = ie_wd_i;
        end

        if (flag_we_i && !rxout_wd_i) begin
            st_d.rxout = 1'b0;
        end

        if (pop) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end

        if (release_req) begin
            st_d.full[st_q.rd_bank] = 1'b0;
            st_d.rd_ptr             = '0;
            st_d.bankf              = 1'b0;
            st_d.rxout              = 1'b0;
            if (NUM_BANKS > 1) begin
                st_d.rd_bank = (st_q.rd_bank == LAST_BANK) ? '0 : st_q.rd_bank + 1'b1;
            end
        end else if (!st_q.bankf && st_q.full[st_q.rd_bank]) begin
            st_d.bankf  = 1'b1;
            st_d.rxout  = 1'b1;
            st_d.rd_ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o    = st_q.full;
    assign rd_bank_o = st_q.rd_bank;
    assign rd_addr_o = st_q.rd_ptr[AW-1:0];
    assign rxout_o   = st_q.rxout;
    assign bankf_o   = st_q.bankf;
    assign ie_o      = st_q.ie;
    assign irq_o     = st_q.rxout && st_q.ie;

    a_r4_ack_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (bankf_o && flag_we_i && bank_wd_i) |=> bankf_o);

    a_r5_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && read_ok_o && !flag_we_i) |=> (remain_o == $past(remain_o) - 1'b1));

    a_r5_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !read_ok_o && !flag_we_i && bankf_o) |=> $stable(remain_o));

    a_r9_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxout_o && !bankf_o && !full_o[rd_bank_o]) |=> !rxout_o);

    a_r6_release_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (bankf_o && flag_we_i && !bank_wd_i) |=> (!bankf_o && !rxout_o));

endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf
    import oep_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_eop,
    input  logic          rx_good,
    output logic          hs_ack,
    output logic          hs_nak,
    input  logic          cpu_flag_we,
    input  logic          cpu_flag_rxout_wd,
    input  logic          cpu_flag_bank_wd,
    input  logic          cpu_ie_we,
    input  logic          cpu_ie_wd,
    input  logic          cpu_rd,
    output logic          rxout_flag,
    output logic          bank_flag,
    output logic          rxout_ie,
    output logic          read_ok,
    output logic [CW-1:0] byte_count,
    output logic [7:0]    rd_data,
    output logic          ep_irq
);

    logic [NUM_BANKS-1:0] full;
    logic                 mem_we;
    logic [BW-1:0]        mem_bank;
    logic [AW-1:0]        mem_addr;
    oep_byte_t            mem_data;
    logic                 commit;
    logic [BW-1:0]        commit_bank;
    logic [CW-1:0]        commit_cnt;
    logic [BW-1:0]        rd_bank;
    logic [AW-1:0]        rd_addr;

    oep_rx_fill #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES)
    ) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_eop       (rx_eop),
        .rx_good      (rx_good),
        .full_i       (full),
        .mem_we_o     (mem_we),
        .mem_bank_o   (mem_bank),
        .mem_addr_o   (mem_addr),
        .mem_data_o   (mem_data),
        .commit_o     (commit),
        .commit_bank_o(commit_bank),
        .commit_cnt_o (commit_cnt),
        .hs_ack_o     (hs_ack),
        .hs_nak_o     (hs_nak)
    );

    oep_bank_mem #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES)
    ) u_mem (
        .clk      (clk),
        .wr_en_i  (mem_we),
        .wr_bank_i(mem_bank),
        .wr_addr_i(mem_addr),
        .wr_data_i(mem_data),
        .rd_bank_i(rd_bank),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

    oep_cpu_view #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES)
    ) u_view (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .commit_bank_i(commit_bank),
        .commit_cnt_i (commit_cnt),
        .flag_we_i    (cpu_flag_we),
        .rxout_wd_i   (cpu_flag_rxout_wd),
        .bank_wd_i    (cpu_flag_bank_wd),
        .ie_we_i      (cpu_ie_we),
        .ie_wd_i      (cpu_ie_wd),
        .rd_i         (cpu_rd),
        .full_o       (full),
        .rd_bank_o    (rd_bank),
        .rd_addr_o    (rd_addr),
        .rxout_o      (rxout_flag),
        .bankf_o      (bank_flag),
        .ie_o         (rxout_ie),
        .remain_o     (byte_count),
        .read_ok_o    (read_ok),
        .irq_o        (ep_irq)
    );

    a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |-> (rxout_flag && rxout_ie));

    a_r2_flags_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxout_flag) |-> bank_flag);

endmodule

// File: tb/usb_out_ep_buf_test.sv
module usb_out_ep_buf_test;

    localparam int NB  = 2;
    localparam int BB  = 8;
    localparam int CW  = $clog2(BB + 1);
    localparam int CYC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          rx_eop = 1'b0;
    logic          rx_good = 1'b0;
    logic          hs_ack, hs_nak;
    logic          cpu_flag_we = 1'b0;
    logic          cpu_flag_rxout_wd = 1'b1;
    logic          cpu_flag_bank_wd = 1'b1;
    logic          cpu_ie_we = 1'b0;
    logic          cpu_ie_wd = 1'b0;
    logic          cpu_rd = 1'b0;
    logic          rxout_flag, bank_flag, rxout_ie, read_ok, ep_irq;
    logic [CW-1:0] byte_count;
    logic [7:0]    rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CYC / 2) clk = ~clk;

    usb_out_ep_buf #(.NUM_BANKS(NB), .BANK_BYTES(BB)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good),
        .hs_ack(hs_ack), .hs_nak(hs_nak),
        .cpu_flag_we(cpu_flag_we), .cpu_flag_rxout_wd(cpu_flag_rxout_wd),
        .cpu_flag_bank_wd(cpu_flag_bank_wd),
        .cpu_ie_we(cpu_ie_we), .cpu_ie_wd(cpu_ie_wd), .cpu_rd(cpu_rd),
        .rxout_flag(rxout_flag), .bank_flag(bank_flag), .rxout_ie(rxout_ie),
        .read_ok(read_ok), .byte_count(byte_count), .rd_data(rd_data), .ep_irq(ep_irq)
    );

    // {len[7:0], good, exp_ack, exp_cnt[7:0]}
    localparam logic [17:0] VEC [6] = '{
        {8'd3,  1'b1, 1'b1, 8'd3},
        {8'd0,  1'b1, 1'b1, 8'd0},
        {8'd5,  1'b0, 1'b0, 8'd0},
        {8'd8,  1'b1, 1'b1, 8'd8},
        {8'd11, 1'b1, 1'b1, 8'd8},
        {8'd1,  1'b1, 1'b1, 8'd1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int len, input logic good, input int seed, input logic rel,
                            output logic got_ack, output logic got_nak, output logic late_hs);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eop   = 1'b1;
        rx_good  = good;
        if (rel) begin
            cpu_flag_we       = 1'b1;
            cpu_flag_rxout_wd = 1'b0;
            cpu_flag_bank_wd  = 1'b0;
        end
        @(negedge clk);
        rx_eop            = 1'b0;
        rx_good           = 1'b0;
        cpu_flag_we       = 1'b0;
        cpu_flag_rxout_wd = 1'b1;
        cpu_flag_bank_wd  = 1'b1;
        got_ack = hs_ack;
        got_nak = hs_nak;
        @(negedge clk);
        late_hs = hs_ack | hs_nak;
    endtask

    task automatic flag_write(input logic rx_wd, input logic bk_wd);
        cpu_flag_we       = 1'b1;
        cpu_flag_rxout_wd = rx_wd;
        cpu_flag_bank_wd  = bk_wd;
        @(negedge clk);
        cpu_flag_we       = 1'b0;
        cpu_flag_rxout_wd = 1'b1;
        cpu_flag_bank_wd  = 1'b1;
        @(negedge clk);
    endtask

    task automatic drain(input string req, input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            check(req, "byte_count before pop", int'(byte_count), n - k);
            check(req, "rd_data order", int'(rd_data), (seed + k) & 8'hFF);
            cpu_rd = 1'b1;
            @(negedge clk);
            cpu_rd = 1'b0;
        end
        check(req, "byte_count drained", int'(byte_count), 0);
        check(req, "read_ok drained", int'(read_ok), 0);
    endtask

    initial begin
        #(CYC * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic a, n, late;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "rxout_flag", int'(rxout_flag), 0);
        check("R1", "bank_flag", int'(bank_flag), 0);
        check("R1", "rxout_ie", int'(rxout_ie), 0);
        check("R1", "read_ok", int'(read_ok), 0);
        check("R1", "byte_count", int'(byte_count), 0);
        check("R1", "ep_irq", int'(ep_irq), 0);
        check("R1", "handshake", int'(hs_ack | hs_nak), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2, R5, R6, R10, R11
        for (int v = 0; v < 6; v++) begin
            int len, cnt, seed;
            logic good, eack;
            len  = int'(VEC[v][17:10]);
            good = VEC[v][9];
            eack = VEC[v][8];
            cnt  = int'(VEC[v][7:0]);
            seed = 16 * (v + 1);
            send_pkt(len, good, seed, 1'b0, a, n, late);
            check(good ? "R2" : "R10", "hs_ack", int'(a), int'(eack));
            check(good ? "R2" : "R10", "hs_nak", int'(n), 0);
            check("R2", "handshake one cycle", int'(late), 0);
            if (eack) begin
                check("R2", "rxout_flag set", int'(rxout_flag), 1);
                check("R2", "bank_flag set", int'(bank_flag), 1);
                check(len > BB ? "R11" : "R2", "byte_count", int'(byte_count), cnt);
                drain("R5", cnt, seed);
                flag_write(1'b0, 1'b0);
                check("R6", "bank_flag released", int'(bank_flag), 0);
                check("R6", "rxout_flag released", int'(rxout_flag), 0);
            end else begin
                check("R10", "rxout_flag stays", int'(rxout_flag), 0);
                check("R10", "bank_flag stays", int'(bank_flag), 0);
            end
        end

        // R3 interrupt gating
        send_pkt(2, 1'b1, 8'h30, 1'b0, a, n, late);
        check("R3", "rxout_flag", int'(rxout_flag), 1);
        check("R3", "ep_irq with ie=0", int'(ep_irq), 0);
        cpu_ie_we = 1'b1;
        cpu_ie_wd = 1'b1;
        @(negedge clk);
        cpu_ie_we = 1'b0;
        check("R3", "ep_irq with ie=1", int'(ep_irq), 1);

        // R9 writing ones changes nothing
        flag_write(1'b1, 1'b1);
        check("R9", "rxout_flag", int'(rxout_flag), 1);
        check("R9", "bank_flag", int'(bank_flag), 1);
        check("R9", "byte_count", int'(byte_count), 2);

        // R4 acknowledge only
        flag_write(1'b0, 1'b1);
        check("R4", "rxout_flag cleared", int'(rxout_flag), 0);
        check("R3", "ep_irq after ack", int'(ep_irq), 0);
        check("R4", "bank_flag kept", int'(bank_flag), 1);
        check("R4", "byte_count kept", int'(byte_count), 2);
        check("R4", "rd_data kept", int'(rd_data), 8'h30);

        // R7 release coincides with end of packet into other bank
        send_pkt(4, 1'b1, 8'h40, 1'b1, a, n, late);
        check("R7", "hs_ack second bank", int'(a), 1);
        check("R7", "rxout_flag again", int'(rxout_flag), 1);
        check("R7", "bank_flag again", int'(bank_flag), 1);
        check("R7", "byte_count new bank", int'(byte_count), 4);
        check("R7", "rd_data new bank", int'(rd_data), 8'h40);
        check("R3", "ep_irq new bank", int'(ep_irq), 1);

        // R7 fill freed bank, R8 then no bank free
        send_pkt(3, 1'b1, 8'h60, 1'b0, a, n, late);
        check("R7", "hs_ack freed bank", int'(a), 1);
        send_pkt(2, 1'b1, 8'h70, 1'b0, a, n, late);
        check("R8", "hs_nak", int'(n), 1);
        check("R8", "hs_ack absent", int'(a), 0);
        check("R8", "held count", int'(byte_count), 4);
        drain("R5", 4, 8'h40);
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        check("R5", "empty read ignored", int'(byte_count), 0);
        check("R5", "bank_flag after empty read", int'(bank_flag), 1);
        flag_write(1'b0, 1'b0);
        @(negedge clk);
        check("R7", "queued bank shown", int'(rxout_flag), 1);
        check("R8", "queued count intact", int'(byte_count), 3);
        drain("R8", 3, 8'h60);
        flag_write(1'b0, 1'b0);
        check("R6", "all released", int'(bank_flag), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule